// File: doc/BRIEF.md
# Spaxel Binning Pipeline

This block sits on a raw detector sample stream and reduces it to binned spatial-spectral elements. Every incoming pixel has a common bias removed and is tested against a saturation cut-off. Pixels that pass are summed into square tiles of `BIN` x `BIN` detector pixels. Pixels that fail are left out of the tile and raise a flag. One spaxel record leaves the block for each tile, holding the tile sum, how many pixels contributed, and a flag word.

Pixels arrive in raster order, each carrying its row and column. Partial tile results for one band of tile rows are kept in a line buffer with one entry per tile column. A tile is emitted the moment its last pixel is accepted. Tiles on the trailing row and column edges of the array are smaller when the array size is not a multiple of `BIN`. The bias and cut-off settings are sampled when the first pixel of a frame is accepted and then held, so a frame is always processed with one set of settings.

Top module: `spx_binner`

## Requirements
- R1: The corrected value of a pixel is its raw sample minus the frame bias, clamped to zero when the bias is larger than the sample.
- R2: A pixel whose corrected value is strictly greater than the frame cut-off is left out of both the tile sum and the tile count, and sets bit 0 of `out_flags` on its tile. A tile whose pixels are all saturated is emitted with sum 0 and count 0.
- R3: A full tile covers `BIN` x `BIN` pixels, and `out_sum` and `out_cnt` are the sum and the number of its non-saturated corrected pixels.
- R4: Tiles in the last tile row or tile column hold only the leftover rows or columns (`ROWS mod BIN`, `COLS mod BIN`) when these are non-zero. Bit 1 of `out_flags` is set exactly on such tiles.
- R5: Tiles are emitted in raster order of tiles (tile row major, tile column minor), with `out_bin_row` = row / `BIN` and `out_bin_col` = col / `BIN`, one record per tile per frame.
- R6: `cfg_bias` and `cfg_sat` are captured when the pixel at row 0, column 0 is accepted, and that pixel already uses the new values. Changes on these inputs at any other time have no effect until the next frame start.
- R7: While `out_valid` is high and `out_ready` is low, the output record stays unchanged and `in_ready` is low.
- R8: After reset `out_valid` is 0 and `in_ready` is 1.
- R9: A tile record is presented on the cycle after its completing pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bias | input | PIX_W | Bias to subtract, captured at frame start |
| cfg_sat | input | PIX_W | Saturation cut-off on corrected values, captured at frame start |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted when high together with in_valid |
| in_row | input | ROW_W | Pixel row |
| in_col | input | COL_W | Pixel column |
| in_data | input | PIX_W | Raw sample |
| out_valid | output | 1 | Spaxel record present |
| out_ready | input | 1 | Downstream takes the record |
| out_bin_row | output | BY_W | Tile row index |
| out_bin_col | output | BX_W | Tile column index |
| out_sum | output | SUM_W | Sum of non-saturated corrected pixels |
| out_cnt | output | CNT_W | Number of non-saturated pixels |
| out_flags | output | 2 | Bit 0: a pixel was saturated; bit 1: trailing-edge tile |

## Verification
A corrupted line-buffer entry would not show at once. It would surface only when the tile that uses the entry completes, up to `BIN` rows of pixels later, as a wrong sum or count, or as a saturation flag that carries over into the next band of tiles. The bench therefore runs several whole frames back to back, so that stale content left from one band or frame is exposed in the next one. A wrong restart decision or a wrong edge decision shows on the first smaller tile as a count that does not match the tile's geometry. A settings latch that follows its inputs shows as a wrong sum in the tiles that complete after a mid-frame change.

// File: rtl/spx_pkg.sv
package spx_pkg;

    typedef struct packed {
        logic edge_bin;
        logic any_sat;
    } spx_flags_t;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/spx_pixel_prep.sv
module spx_pixel_prep #(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic             sof,
    input  logic [PIX_W-1:0] raw,
    input  logic [PIX_W-1:0] cfg_bias,
    input  logic [PIX_W-1:0] cfg_sat,
    output logic [PIX_W-1:0] pix_val,
    output logic             pix_sat
);
    logic [PIX_W-1:0] bias_q, sat_q;
    logic [PIX_W-1:0] bias_eff, sat_eff;

    always_comb begin
        bias_eff = sof ? cfg_bias : bias_q;
        sat_eff  = sof ? cfg_sat  : sat_q;
        pix_val  = (raw > bias_eff) ? (raw - bias_eff) : '0;
        pix_sat  = pix_val > sat_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bias_q <= '0;
            sat_q  <= '1;
        end else if (acc && sof) begin
            bias_q <= cfg_bias;
            sat_q  <= cfg_sat;
        end
    end

    // R6: settings move only on an accepted frame-start pixel
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(acc && sof) |=> ($stable(bias_q) && $stable(sat_q)));

endmodule

// File: rtl/spx_bin_geom.sv
module spx_bin_geom #(
    parameter int ROWS = 512,
    parameter int COLS = 512,
    parameter int BIN  = 5,
    localparam int ROW_W = spx_pkg::idx_w(ROWS),
    localparam int COL_W = spx_pkg::idx_w(COLS),
    localparam int NBY   = spx_pkg::ceil_div(ROWS, BIN),
    localparam int NBX   = spx_pkg::ceil_div(COLS, BIN),
    localparam int BY_W  = spx_pkg::idx_w(NBY),
    localparam int BX_W  = spx_pkg::idx_w(NBX)
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [BY_W-1:0]  by,
    output logic [BX_W-1:0]  bx,
    output logic             sof,
    output logic             band_first,
    output logic             tile_first,
    output logic             tile_last,
    output logic             edge_bin
);
    localparam int ROW_REM = ROWS % BIN;
    localparam int COL_REM = COLS % BIN;

    int unsigned r_in, c_in;
    logic last_r, last_c;

    always_comb begin
        r_in       = int'(row) % BIN;
        c_in       = int'(col) % BIN;
        by         = BY_W'(int'(row) / BIN);
        bx         = BX_W'(int'(col) / BIN);
        sof        = (row == '0) && (col == '0);
        band_first = (r_in == 0);
        tile_first = band_first && (c_in == 0);
        last_r     = (r_in == BIN - 1) || (int'(row) == ROWS - 1);
        last_c     = (c_in == BIN - 1) || (int'(col) == COLS - 1);
        tile_last  = last_r && last_c;
    end

    logic edge_r, edge_c;
    generate
        if (ROW_REM != 0) begin : g_row_edge
            assign edge_r = (int'(by) == NBY - 1);
        end else begin : g_row_full
            assign edge_r = 1'b0;
        end
        if (COL_REM != 0) begin : g_col_edge
            assign edge_c = (int'(bx) == NBX - 1);
        end else begin : g_col_full
            assign edge_c = 1'b0;
        end
    endgenerate

    assign edge_bin = edge_r || edge_c;

endmodule

// File: rtl/spx_line_acc.sv
module spx_line_acc #(
    parameter int COLS  = 512,
    parameter int BIN   = 5,
    parameter int PIX_W = 16,
    localparam int NBX   = spx_pkg::ceil_div(COLS, BIN),
    localparam int BX_W  = spx_pkg::idx_w(NBX),
    localparam int CNT_W = $clog2(BIN * BIN + 1),
    localparam int SUM_W = PIX_W + $clog2(BIN * BIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic [BX_W-1:0]  bx,
    input  logic             tile_first,
    input  logic [PIX_W-1:0] pix_val,
    input  logic             pix_sat,
    output logic [SUM_W-1:0] new_sum,
    output logic [CNT_W-1:0] new_cnt,
    output logic             new_sat
);
    logic [SUM_W-1:0] sum_q [NBX];
    logic [CNT_W-1:0] cnt_q [NBX];
    logic             sat_q [NBX];

    logic [SUM_W-1:0] base_sum;
    logic [CNT_W-1:0] base_cnt;
    logic             base_sat;

    always_comb begin
        base_sum = tile_first ? '0   : sum_q[bx];
        base_cnt = tile_first ? '0   : cnt_q[bx];
        base_sat = tile_first ? 1'b0 : sat_q[bx];
        new_sum  = base_sum + (pix_sat ? '0 : SUM_W'(pix_val));
        new_cnt  = base_cnt + CNT_W'(!pix_sat);
        new_sat  = base_sat | pix_sat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBX; i++) begin
                cnt_q[i] <= '0;
                sat_q[i] <= 1'b0;
            end
        end else if (acc) begin
            sum_q[bx] <= new_sum;
            cnt_q[bx] <= new_cnt;
            sat_q[bx] <= new_sat;
        end
    end

endmodule

// File: rtl/spx_binner.sv
module spx_binner #(
    parameter int ROWS  = 512,
    parameter int COLS  = 512,
    parameter int BIN   = 5,
    parameter int PIX_W = 16,
    localparam int ROW_W = spx_pkg::idx_w(ROWS),
    localparam int COL_W = spx_pkg::idx_w(COLS),
    localparam int NBY   = spx_pkg::ceil_div(ROWS, BIN),
    localparam int NBX   = spx_pkg::ceil_div(COLS, BIN),
    localparam int BY_W  = spx_pkg::idx_w(NBY),
    localparam int BX_W  = spx_pkg::idx_w(NBX),
    localparam int CNT_W = $clog2(BIN * BIN + 1),
    localparam int SUM_W = PIX_W + $clog2(BIN * BIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] cfg_bias,
    input  logic [PIX_W-1:0] cfg_sat,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ROW_W-1:0] in_row,
    input  logic [COL_W-1:0] in_col,
    input  logic [PIX_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BY_W-1:0]  out_bin_row,
    output logic [BX_W-1:0]  out_bin_col,
    output logic [SUM_W-1:0] out_sum,
    output logic [CNT_W-1:0] out_cnt,
    output logic [1:0]       out_flags
);
    import spx_pkg::*;

    logic             acc;
    logic [BY_W-1:0]  by;
    logic [BX_W-1:0]  bx;
    logic             sof, band_first, tile_first, tile_last, edge_bin;
    logic [PIX_W-1:0] pix_val;
    logic             pix_sat;
    logic [SUM_W-1:0] new_sum;
    logic [CNT_W-1:0] new_cnt;
    logic             new_sat;
    spx_flags_t       flags_q;

    assign in_ready = !out_valid || out_ready;
    assign acc      = in_valid && in_ready;

    spx_bin_geom #(.ROWS(ROWS), .COLS(COLS), .BIN(BIN)) geom_i (
        .row(in_row), .col(in_col), .by(by), .bx(bx), .sof(sof),
        .band_first(band_first), .tile_first(tile_first),
        .tile_last(tile_last), .edge_bin(edge_bin)
    );

    spx_pixel_prep #(.PIX_W(PIX_W)) prep_i (
        .clk(clk), .rst(rst), .acc(acc), .sof(sof), .raw(in_data),
        .cfg_bias(cfg_bias), .cfg_sat(cfg_sat),
        .pix_val(pix_val), .pix_sat(pix_sat)
    );

    spx_line_acc #(.COLS(COLS), .BIN(BIN), .PIX_W(PIX_W)) lacc_i (
        .clk(clk), .rst(rst), .acc(acc), .bx(bx), .tile_first(tile_first),
        .pix_val(pix_val), .pix_sat(pix_sat),
        .new_sum(new_sum), .new_cnt(new_cnt), .new_sat(new_sat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_bin_row <= '0;
            out_bin_col <= '0;
            out_sum     <= '0;
            out_cnt     <= '0;
            flags_q     <= '0;
        end else if (acc && tile_last) begin
            out_valid        <= 1'b1;
            out_bin_row      <= by;
            out_bin_col      <= bx;
            out_sum          <= new_sum;
            out_cnt          <= new_cnt;
            flags_q.any_sat  <= new_sat;
            flags_q.edge_bin <= edge_bin;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_flags = flags_q;

    // R3: a tile never reports more pixels than it can hold
    p_cnt_max_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_cnt) <= BIN * BIN));

    // R3/R4: a full, clean tile reports every pixel
    p_full_tile_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_flags[1] && !out_flags[0]) |-> (int'(out_cnt) == BIN * BIN));

    // R2: an empty tile can only come from saturation
    p_empty_sat_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cnt == '0) |-> out_flags[0]);

    // R7: a stalled record holds
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) &&
                                       $stable(out_cnt) && $stable(out_flags)));

    // R5: coordinates stay inside the array
    p_coord_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ((int'(in_row) < ROWS) && (int'(in_col) < COLS)));

endmodule

// File: tb/spx_binner_tb_top.sv
module spx_binner_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS  = 7;
    localparam int COLS  = 12;
    localparam int BIN   = 5;
    localparam int PIX_W = 16;
    localparam int NBY   = 2;
    localparam int NBX   = 3;
    localparam int NSPX  = NBY * NBX;
    localparam int NPIX  = ROWS * COLS;

    typedef struct packed {
        logic [15:0] bias;
        logic [15:0] sat;
        logic [7:0]  seed;
        logic [1:0]  mode;
        logic        chg;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'd0,   16'hFFFF, 8'd0, 2'd0, 1'b0},
        '{16'd150, 16'hFFFF, 8'd1, 2'd1, 1'b0},
        '{16'd50,  16'd200,  8'd2, 2'd0, 1'b0},
        '{16'd0,   16'd0,    8'd3, 2'd0, 1'b0},
        '{16'd20,  16'd150,  8'd4, 2'd1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PIX_W-1:0] cfg_bias = '0, cfg_sat = '1;
    logic in_valid = 1'b0, in_ready;
    logic [2:0] in_row = '0;
    logic [3:0] in_col = '0;
    logic [PIX_W-1:0] in_data = '0;
    logic out_valid, out_ready = 1'b1;
    logic [0:0] out_bin_row;
    logic [1:0] out_bin_col;
    logic [20:0] out_sum;
    logic [4:0] out_cnt;
    logic [1:0] out_flags;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int exp_sum [NSPX], exp_cnt [NSPX], exp_sat [NSPX], exp_edge [NSPX];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spx_binner #(.ROWS(ROWS), .COLS(COLS), .BIN(BIN), .PIX_W(PIX_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_bias(cfg_bias), .cfg_sat(cfg_sat),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
        .in_col(in_col), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_bin_row(out_bin_row),
        .out_bin_col(out_bin_col), .out_sum(out_sum), .out_cnt(out_cnt),
        .out_flags(out_flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int raw_pix(input int r, input int c, input int seed);
        return 100 + ((r * 37 + c * 11 + seed * 53) % 256);
    endfunction

    task automatic fill_expected(input int bias, input int sat, input int seed);
        for (int k = 0; k < NSPX; k++) begin
            exp_sum[k] = 0; exp_cnt[k] = 0; exp_sat[k] = 0;
            exp_edge[k] = ((k / NBX) * BIN + BIN > ROWS || (k % NBX) * BIN + BIN > COLS) ? 1 : 0;
        end
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                int v, k;
                v = raw_pix(r, c, seed) - bias;
                if (v < 0) v = 0;
                k = (r / BIN) * NBX + (c / BIN);
                if (v > sat) exp_sat[k] = 1;
                else begin exp_sum[k] += v; exp_cnt[k]++; end
            end
    endtask

    task automatic run_frame(input vec_t v);
        int p = 0, got = 0, cyc = 0, stallcnt = 0;
        bit pend = 0, released = 0;
        fill_expected(int'(v.bias), int'(v.sat), int'(v.seed));
        @(negedge clk);
        cfg_bias = v.bias;
        cfg_sat  = v.sat;
        while ((p < NPIX || got < NSPX) && !done) begin
            @(negedge clk);
            cyc++;
            if (pend) begin chk("R9 record one cycle after completing pixel", int'(out_valid), 1); pend = 0; end
            case (v.mode)
                2'd0: out_ready = 1'b1;
                2'd1: out_ready = (cyc % 3) != 0;
                default: out_ready = released;
            endcase
            if (p < NPIX) begin
                in_valid = (v.mode == 2'd1) ? ((cyc % 4) != 1) : 1'b1;
                in_row   = 3'(p / COLS);
                in_col   = 4'(p % COLS);
                in_data  = PIX_W'(raw_pix(p / COLS, p % COLS, int'(v.seed)));
            end else in_valid = 1'b0;
            #1;
            if (v.mode == 2'd2 && out_valid && !out_ready) begin
                stallcnt++;
                if (stallcnt == 4) begin
                    chk("R7 in_ready low while stalled", int'(in_ready), 0);
                    chk("R7 stalled sum held", int'(out_sum), exp_sum[0]);
                    chk("R7 stalled count held", int'(out_cnt), exp_cnt[0]);
                    released = 1;
                end
            end
            if (out_valid && out_ready) begin
                if (got < NSPX) begin
                    chk("R5 tile row index", int'(out_bin_row), got / NBX);
                    chk("R5 tile column index", int'(out_bin_col), got % NBX);
                    chk("R1/R3 tile sum", int'(out_sum), exp_sum[got]);
                    chk("R2/R3 tile count", int'(out_cnt), exp_cnt[got]);
                    chk("R2 saturation flag", int'(out_flags[0]), exp_sat[got]);
                    chk("R4 edge flag", int'(out_flags[1]), exp_edge[got]);
                end
                got++;
            end
            if (in_valid && in_ready) begin
                int r, c;
                r = p / COLS; c = p % COLS;
                if (((r % BIN) == BIN - 1 || r == ROWS - 1) && ((c % BIN) == BIN - 1 || c == COLS - 1))
                    pend = (v.mode == 2'd0);
                if (v.chg && p == 20) begin
                    cfg_bias = 16'd999;   // R6: must be ignored mid-frame
                    cfg_sat  = 16'd1;
                end
                p++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R5 one record per tile", got, NSPX);
        chk("R5 no extra record", int'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 out_valid after reset", int'(out_valid), 0);
        chk("R8 in_ready after reset", int'(in_ready), 1);
        for (int i = 0; i < 5; i++) run_frame(VECS[i]);
        run_frame('{16'd0, 16'hFFFF, 8'd5, 2'd2, 1'b0});
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule